// File: doc/BRIEF.md
# Chained Token-Passing FIFO Buffer

This block joins several identical synchronous FIFO slices into one deeper first-in first-out buffer. All slices share a single write bus and a single read bus. Write and read each have their own clock and enable. Two tokens decide which slice takes part in each transfer. The slice that holds the write token stores incoming words. The slice that holds the read token supplies outgoing words. Each token travels around its own ring of slices. A slice hands on its token with a one-cycle pulse on its expansion output, and the next slice picks the token up from its expansion input.

A first-load strap picks the slice that owns both tokens after reset. In this wrapper that is slice 0, whose strap is tied low; every other slice has its strap tied high. A slice keeps the write token until its own memory has taken a full round of words. It keeps the read token until it has handed out a full round of words. Because of this, the words move through the slices in a fixed rotation, and the chain holds the slice depth times the number of slices.

Each slice gives empty, full, almost-empty and almost-full flags, and each slice raises a flag only while it holds the token that the flag concerns. The chain flags are the OR of the slice flags. A slice that is not chosen drives zero on its data output, so the slice outputs can be ORed together. No half-full indication is provided.

Top module: `ring_fifo_chain`

## Requirements
- R1: After reset, empty and almost_empty are 1, full and almost_full are 0, rd_valid is 0, and slice 0 holds both tokens.
- R2: Words come out in the order they were accepted, across every slice boundary and across wraparound of the whole chain.
- R3: Exactly one slice holds the write token at all times. The holder passes it to the next slice in the ring, with a one-cycle pulse, in the same write-clock cycle that it stores word number SLICE_DEPTH of its turn.
- R4: Exactly one slice holds the read token at all times. The holder passes it to the next slice in the ring, with a one-cycle pulse, in the same read-clock cycle that it reads word number SLICE_DEPTH of its turn.
- R5: With no reads, full stays 0 after SLICE_DEPTH*SLICES-1 accepted writes and becomes 1 right after write number SLICE_DEPTH*SLICES. While full is 1, writes are ignored, so no extra word is ever read out.
- R6: Once the chain has been drained, empty is 1. A read request while empty is ignored: rd_valid stays 0 and no word is lost.
- R7: A write is accepted when wr_en=1 and full=0 at a wr_clk rising edge. A read is accepted when rd_en=1 and empty=0 at a rd_clk rising edge. After an accepted read, rd_valid is 1 with the word on rd_data for exactly the next rd_clk cycle. At any time at most one slice drives a word.
- R8: Within the chain the almost flags are only approximate. almost_full is 1 whenever the chain is full or one word short of full. almost_empty is 1 whenever the chain is empty.
- R9: A long stream of random mixed writes and reads, running for many passes around both rings, keeps the data in order and never loses a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | OR of the slice data outputs; valid when rd_valid is 1 |
| rd_valid | output | 1 | High for one read cycle after an accepted read |
| empty | output | 1 | Chain empty (OR of slice empty flags) |
| full | output | 1 | Chain full (OR of slice full flags) |
| almost_empty | output | 1 | Approximate near-empty (OR of slices) |
| almost_full | output | 1 | Approximate near-full (OR of slices) |

## Verification
If a token is misplaced, or two slices hold the same token, the error shows up at rd_data within one slice depth of transfers. Words appear out of order near a multiple of SLICE_DEPTH, or two words ORed together appear in the same cycle. A pointer or count error shows up as a full flag that is early or late against the exact count of accepted writes, or as rd_valid appearing while the chain reports empty. A read-path error shows up as a data mismatch on the cycle right after the read.

// File: rtl/fifo_chain_pkg.sv
package fifo_chain_pkg;

    // Widest pointer supported: 4096 words plus a wrap bit.
    localparam int PTR_MAX = 13;
    typedef logic [PTR_MAX-1:0] ptr_t;

    function automatic ptr_t bin2gray(input ptr_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic ptr_t gray2bin(input ptr_t g);
        ptr_t b;
        b[PTR_MAX-1] = g[PTR_MAX-1];
        for (int i = PTR_MAX - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/ptr_sync.sv
module ptr_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.meta   = din;
        s_d.stable = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign dout = s_q.stable;
endmodule

// File: rtl/slice_mem.sv
module slice_mem #(
    parameter int DW    = 18,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] store_q [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) begin
            store_q[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata = store_q[raddr];
    end
endmodule

// File: rtl/fifo_slice.sv
module fifo_slice
    import fifo_chain_pkg::*;
#(
    parameter int DW     = 18,
    parameter int DEPTH  = 64,
    parameter int AE_LVL = 8,
    parameter int AF_LVL = 8
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          first_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          wxi,
    output logic          wxo,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    input  logic          rxi,
    output logic          rxo,
    output logic          empty,
    output logic          full,
    output logic          almost_empty,
    output logic          almost_full,
    output logic          wtok,
    output logic          rtok
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    typedef struct packed {
        logic          tok;
        logic [PW-1:0] ptr;
        logic [PW-1:0] gray;
    } wside_t;

    typedef struct packed {
        logic          tok;
        logic [PW-1:0] ptr;
        logic [PW-1:0] gray;
        logic          valid;
        logic [DW-1:0] data;
    } rside_t;

    wside_t w_d, w_q;
    rside_t r_d, r_q;

    logic [PW-1:0] rgray_sync, wgray_sync;
    logic [PW-1:0] rptr_seen, wptr_seen;
    logic [PW-1:0] wcount, rcount;
    logic          wfull, rempty, wdo, rdo, wlast, rlast;
    logic [DW-1:0] mem_rdata;

    // Pointer crossing between the two clock domains.
    ptr_sync #(.W(PW)) u_rsync (
        .clk(wr_clk), .rst_n(rst_n), .din(r_q.gray), .dout(rgray_sync)
    );
    ptr_sync #(.W(PW)) u_wsync (
        .clk(rd_clk), .rst_n(rst_n), .din(w_q.gray), .dout(wgray_sync)
    );

    slice_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
        .wr_clk(wr_clk),
        .we    (wdo),
        .waddr (w_q.ptr[AW-1:0]),
        .wdata (wr_data),
        .raddr (r_q.ptr[AW-1:0]),
        .rdata (mem_rdata)
    );

    // ---------------- write domain ----------------
    always_comb begin
        rptr_seen = PW'(gray2bin(ptr_t'(rgray_sync)));
        wcount    = w_q.ptr - rptr_seen;
        wfull     = (wcount == PW'(DEPTH));
        wdo       = w_q.tok & wr_en & ~wfull;
        wlast     = wdo & (w_q.ptr[AW-1:0] == {AW{1'b1}});

        w_d = w_q;
        if (wdo) begin
            w_d.ptr = w_q.ptr + 1'b1;
        end
        w_d.gray = PW'(bin2gray(ptr_t'(w_d.ptr)));
        if (wlast) begin
            w_d.tok = 1'b0;
        end
        if (wxi) begin
            w_d.tok = 1'b1;
        end
    end

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q     <= '0;
            w_q.tok <= ~first_n;
        end else begin
            w_q <= w_d;
        end
    end

    // ---------------- read domain ----------------
    always_comb begin
        wptr_seen = PW'(gray2bin(ptr_t'(wgray_sync)));
        rcount    = wptr_seen - r_q.ptr;
        rempty    = (rcount == '0);
        rdo       = r_q.tok & rd_en & ~rempty;
        rlast     = rdo & (r_q.ptr[AW-1:0] == {AW{1'b1}});

        r_d       = r_q;
        r_d.valid = rdo;
        r_d.data  = rdo ? mem_rdata : '0;
        if (rdo) begin
            r_d.ptr = r_q.ptr + 1'b1;
        end
        r_d.gray = PW'(bin2gray(ptr_t'(r_d.ptr)));
        if (rlast) begin
            r_d.tok = 1'b0;
        end
        if (rxi) begin
            r_d.tok = 1'b1;
        end
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.tok <= ~first_n;
        end else begin
            r_q <= r_d;
        end
    end

    // ---------------- outputs ----------------
    assign wxo          = wlast;
    assign rxo          = rlast;
    assign wtok         = w_q.tok;
    assign rtok         = r_q.tok;
    assign rd_data      = r_q.data;
    assign rd_valid     = r_q.valid;
    assign full         = w_q.tok & wfull;
    assign almost_full  = w_q.tok & (wcount >= PW'(DEPTH - AF_LVL));
    assign empty        = r_q.tok & rempty;
    assign almost_empty = r_q.tok & (rcount <= PW'(AE_LVL));

    // ---------------- assertions ----------------
    // R3: hand-off pulse lasts a single write cycle
    p_wxo_pulse_r3: assert property (@(posedge wr_clk) disable iff (!rst_n)
        wxo |=> !wxo);
    // R4: hand-off pulse lasts a single read cycle
    p_rxo_pulse_r4: assert property (@(posedge rd_clk) disable iff (!rst_n)
        rxo |=> !rxo);
    // R5: the stored count never exceeds the slice depth
    p_no_overflow_r5: assert property (@(posedge wr_clk) disable iff (!rst_n)
        wcount <= PW'(DEPTH));
    // R6: a read request while empty yields no data
    p_empty_no_data_r6: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (rd_en && empty) |=> !rd_valid);
    // R7: a slice without the read token drives nothing
    p_idle_zero_r7: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !rtok |=> (rd_data == '0 || $past(rtok)));
endmodule

// File: rtl/ring_fifo_chain.sv
module ring_fifo_chain #(
    parameter int DATA_W      = 18,
    parameter int SLICE_DEPTH = 64,
    parameter int SLICES      = 3,
    parameter int AE_LVL      = 8,
    parameter int AF_LVL      = 8
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              empty,
    output logic              full,
    output logic              almost_empty,
    output logic              almost_full
);
    logic [SLICES-1:0] wxo_v, rxo_v, wtok_v, rtok_v, valid_v;
    logic [SLICES-1:0] empty_v, full_v, ae_v, af_v;
    logic [DATA_W-1:0] data_v [SLICES];

    for (genvar i = 0; i < SLICES; i++) begin : g_slice
        localparam int PREV = (i + SLICES - 1) % SLICES;
        fifo_slice #(
            .DW(DATA_W), .DEPTH(SLICE_DEPTH), .AE_LVL(AE_LVL), .AF_LVL(AF_LVL)
        ) u_slice (
            .wr_clk      (wr_clk),
            .rd_clk      (rd_clk),
            .rst_n       (rst_n),
            .first_n     ((i == 0) ? 1'b0 : 1'b1),
            .wr_en       (wr_en),
            .wr_data     (wr_data),
            .wxi         (wxo_v[PREV]),
            .wxo         (wxo_v[i]),
            .rd_en       (rd_en),
            .rd_data     (data_v[i]),
            .rd_valid    (valid_v[i]),
            .rxi         (rxo_v[PREV]),
            .rxo         (rxo_v[i]),
            .empty       (empty_v[i]),
            .full        (full_v[i]),
            .almost_empty(ae_v[i]),
            .almost_full (af_v[i]),
            .wtok        (wtok_v[i]),
            .rtok        (rtok_v[i])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < SLICES; i++) begin
            rd_data = rd_data | data_v[i];
        end
    end

    assign rd_valid     = |valid_v;
    assign empty        = |empty_v;
    assign full         = |full_v;
    assign almost_empty = |ae_v;
    assign almost_full  = |af_v;

    // R3: exactly one write token in the ring
    p_one_wtok_r3: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $countones(wtok_v) == 1);
    // R4: exactly one read token in the ring
    p_one_rtok_r4: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $countones(rtok_v) == 1);
    // R7: never two slices presenting data together
    p_one_source_r7: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $onehot0(valid_v));
    // R5: full and empty never both claimed by the chain
    p_not_both_r5: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !(full && empty));
endmodule

// File: tb/ring_fifo_chain_tb.sv
module ring_fifo_chain_tb;
    localparam int DW    = 18;
    localparam int DEPTH = 64;
    localparam int NS    = 3;
    localparam int CAP   = DEPTH * NS;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_en, rd_en;
    logic [DW-1:0] wr_data;
    logic [DW-1:0] rd_data;
    logic          rd_valid, empty, full, almost_empty, almost_full;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [DW-1:0] exp_q [$];
    bit            pend = 1'b0;
    logic [DW-1:0] pend_word = '0;

    always #2.5 clk = ~clk;

    ring_fifo_chain #(
        .DATA_W(DW), .SLICE_DEPTH(DEPTH), .SLICES(NS), .AE_LVL(8), .AF_LVL(8)
    ) u_dut (
        .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .empty(empty), .full(full),
        .almost_empty(almost_empty), .almost_full(almost_full)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Called just after a falling edge: check last read, drive one cycle.
    task automatic step(input bit we, input logic [DW-1:0] d, input bit re);
        if (pend) begin
            check(rd_valid == 1'b1, "R7 rd_valid after read", 32'(rd_valid), 32'd1);
            check(rd_data == pend_word, "R2 order R3 R4 R9 data", 32'(rd_data), 32'(pend_word));
        end else begin
            check(rd_valid == 1'b0, "R7 R6 no spurious data", 32'(rd_valid), 32'd0);
        end
        pend = 1'b0;
        if (we && !full) begin
            exp_q.push_back(d);
        end
        if (re && !empty) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 empty low with nothing stored", 32'(empty), 32'd1);
            end else begin
                pend      = 1'b1;
                pend_word = exp_q.pop_front();
            end
        end
        wr_en   = we;
        wr_data = d;
        rd_en   = re;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20241));
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(empty == 1'b1, "R1 empty", 32'(empty), 32'd1);
        check(almost_empty == 1'b1, "R1 almost_empty", 32'(almost_empty), 32'd1);
        check(full == 1'b0, "R1 full", 32'(full), 32'd0);
        check(almost_full == 1'b0, "R1 almost_full", 32'(almost_full), 32'd0);
        check(rd_valid == 1'b0, "R1 rd_valid", 32'(rd_valid), 32'd0);

        // R5: fill to one short of capacity, then the last word
        for (int i = 0; i < CAP - 1; i++) step(1'b1, DW'(i * 7 + 3), 1'b0);
        check(full == 1'b0, "R5 not full at CAP-1", 32'(full), 32'd0);
        check(almost_full == 1'b1, "R8 almost_full at CAP-1", 32'(almost_full), 32'd1);
        step(1'b1, DW'(18'h2aaaa), 1'b0);
        check(full == 1'b1, "R5 full at CAP", 32'(full), 32'd1);
        check(almost_full == 1'b1, "R8 almost_full when full", 32'(almost_full), 32'd1);
        // R5: writes while full are dropped
        for (int i = 0; i < 5; i++) step(1'b1, DW'(18'h3ffff), 1'b0);
        check(full == 1'b1, "R5 still full", 32'(full), 32'd1);
        repeat (4) step(1'b0, '0, 1'b0);
        check(empty == 1'b0, "R6 not empty when full", 32'(empty), 32'd0);

        // R2 R3 R4: drain across both slice boundaries
        for (int i = 0; i < CAP; i++) step(1'b0, '0, 1'b1);
        step(1'b0, '0, 1'b0);
        check(empty == 1'b1, "R6 empty after drain", 32'(empty), 32'd1);
        check(almost_empty == 1'b1, "R8 almost_empty when empty", 32'(almost_empty), 32'd1);
        check(exp_q.size() == 0, "R5 R6 word count read out", 32'(exp_q.size()), 32'd0);

        // R6: reads on empty do nothing
        for (int i = 0; i < 5; i++) step(1'b0, '0, 1'b1);
        check(empty == 1'b1, "R6 stays empty", 32'(empty), 32'd1);

        // R9: random mix, write-leaning then read-leaning, several ring passes
        for (int i = 0; i < 3000; i++)
            step(($urandom % 4) != 0, DW'($urandom), ($urandom % 3) == 0);
        for (int i = 0; i < 3000; i++)
            step(($urandom % 3) == 0, DW'($urandom), ($urandom % 4) != 0);
        for (int i = 0; i < 4000; i++)
            step(($urandom % 2) == 0, DW'($urandom), ($urandom % 2) == 0);
        for (int i = 0; i < 2 * CAP + 20 && (exp_q.size() != 0 || pend); i++)
            step(1'b0, '0, 1'b1);
        repeat (4) step(1'b0, '0, 1'b0);
        check(exp_q.size() == 0, "R9 all words returned", 32'(exp_q.size()), 32'd0);
        check(empty == 1'b1, "R9 R6 empty at end", 32'(empty), 32'd1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule